// File: doc/BRIEF.md
# Configurable Logic-Cell Storage Element

This block is one output cell of a sum-of-products programmable fabric. It receives the OR-sum of its product terms and a set of static configuration bits. It conditions that sum with an optional inversion. It then passes the sum straight through, or holds it in a storage element that acts as a D flip-flop, a toggle flip-flop or a level-sensitive latch. The storage element is clocked or enabled by one of several global clock lines. The cell's result goes to two places: a pin path, which can be switched off when the pin serves as an input, and a feedback path into the interconnect, which is always live.

The fabric runs on one system clock `clk`. The global clock lines are sampled on that clock. A flip-flop mode acts on the first system edge at which the selected line is seen high after being low. An asynchronous clear and an asynchronous set force the outputs in the same cycle, without waiting for any edge, and they also load the stored bit at the next system edge. A parameter builds the cell as a buried cell, which has no pin. A buried cell can also act as an input register or input latch that captures the pin of the neighbouring cell.

Top module: `mc_cell`

## Requirements
- R1: With `cfg_mode` = 0 (pass-through), `fb_q` equals `sum_in ^ cfg_inv` in the same cycle, with no clock involved. Mode codes 6 and 7 behave like code 0.
- R2: When `cfg_inv` = 1, the sum is inverted before it reaches the storage element, so a flip-flop captures `~sum_in`.
- R3: With `cfg_mode` = 1 (D flip-flop), the stored bit takes the conditioned sum at the first `clk` rising edge at which the selected global clock is sampled high after it was sampled low. Between such edges the stored bit holds.
- R4: With `cfg_mode` = 2 (toggle flip-flop), the stored bit inverts on each detected global clock rise while the conditioned sum is 1. It holds when the conditioned sum is 0.
- R5: With `cfg_mode` = 3 (latch), `fb_q` follows the conditioned sum in the same cycle while the selected global clock is high. It keeps the last value that was sampled while the clock was high.
- R6: `cfg_clk_sel` picks global clock `gclk[cfg_clk_sel]`. Activity on any other global clock line leaves the cell unchanged.
- R7: `arst` = 1 forces `fb_q` to 0 in the same cycle, independent of any clock. The stored bit becomes 0 and stays 0 after `arst` falls. `arst` wins over `apre`.
- R8: `apre` = 1 (with `arst` = 0) forces `fb_q` to 1 in the same cycle. The stored bit becomes 1 and stays 1 after `apre` falls.
- R9: In a cell with a pin (`BURIED` = 0), `pin_q` equals `fb_q` when `cfg_pin_en` = 1 and is 0 otherwise. `fb_q` does not depend on `cfg_pin_en`. In a buried cell `pin_q` is always 0.
- R10: In a buried cell, `cfg_mode` = 4 is an input register and `cfg_mode` = 5 is an input latch. Both take their data from `nbr_pin` without inversion and use the selected global clock. In a cell with a pin, codes 4 and 5 act as code 0.
- R11: The synchronous reset `rst` clears the stored bit to 0 at the next `clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of the fabric |
| rst | input | 1 | Synchronous active-high reset |
| gclk | input | NUM_GCLK | Global clock / enable lines, sampled on clk |
| cfg_clk_sel | input | GSEL_W | Index of the global clock used by this cell |
| cfg_mode | input | 3 | Storage mode code (see R1 to R10) |
| cfg_inv | input | 1 | Invert the sum before storage |
| cfg_pin_en | input | 1 | Drive the cell's result onto the pin path |
| sum_in | input | 1 | Sum-of-products term |
| nbr_pin | input | 1 | Neighbouring cell's pin, data for input modes |
| arst | input | 1 | Asynchronous clear, forces 0 |
| apre | input | 1 | Asynchronous set, forces 1 |
| pin_q | output | 1 | Pin path result |
| fb_q | output | 1 | Feedback result to the interconnect |

## Verification
Two things can land in the same cycle: a detected rise of the selected global clock and an active clear or set. The bench raises `arst` and `apre` together while a flip-flop holds a 1, and samples `fb_q` before and after the next system edge. It judges the outcome by clear precedence and by the stored bit once both are released. A second collision comes from the latch. Dropping its enable in the same cycle as the sum changes must keep the value captured at the previous edge, and the bench checks for that value.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [2:0] {
    MD_PASS   = 3'd0,
    MD_DFF    = 3'd1,
    MD_TFF    = 3'd2,
    MD_LAT    = 3'd3,
    MD_IN_DFF = 3'd4,
    MD_IN_LAT = 3'd5
  } mc_mode_e;

  function automatic logic is_edge_mode(mc_mode_e m);
    return (m == MD_DFF) || (m == MD_TFF) || (m == MD_IN_DFF);
  endfunction

  function automatic logic is_level_mode(mc_mode_e m);
    return (m == MD_LAT) || (m == MD_IN_LAT);
  endfunction
endpackage

// File: rtl/mc_clksel.sv
module mc_clksel #(
  parameter int NUM_GCLK = 2,
  localparam int GSEL_W = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic [GSEL_W-1:0]   sel,
  output logic                lvl,
  output logic                rise
);
  logic [NUM_GCLK-1:0] gclk_d;

  always_ff @(posedge clk) begin
    if (rst) gclk_d <= '0;
    else     gclk_d <= gclk;
  end

  assign lvl  = gclk[sel];
  assign rise = gclk[sel] & ~gclk_d[sel];

  // R3: with a steady selection a rise can never be seen twice in a row
  p_single_rise_r3: assert property (@(posedge clk) disable iff (rst)
    ($stable(sel) && rise) |=> !rise);
endmodule

// File: rtl/mc_store.sv
module mc_store
  import mc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  mc_mode_e mode,
  input  logic     d,
  input  logic     en_lvl,
  input  logic     rise,
  input  logic     arst,
  input  logic     apre,
  output logic     res
);
  logic q_r;
  logic edge_m, lvl_m;

  assign edge_m = is_edge_mode(mode);
  assign lvl_m  = is_level_mode(mode);

  always_ff @(posedge clk) begin
    if (rst)       q_r <= 1'b0;
    else if (arst) q_r <= 1'b0;
    else if (apre) q_r <= 1'b1;
    else if (edge_m && rise) begin
      if (mode == MD_TFF) q_r <= q_r ^ d;
      else                q_r <= d;
    end else if (lvl_m && en_lvl) begin
      q_r <= d;
    end
  end

  always_comb begin
    if (arst)        res = 1'b0;
    else if (apre)   res = 1'b1;
    else if (edge_m) res = q_r;
    else if (lvl_m)  res = en_lvl ? d : q_r;
    else             res = d;
  end

  // R3: D capture on a detected rise
  p_dff_capture_r3: assert property (@(posedge clk) disable iff (rst)
    ((mode == MD_DFF || mode == MD_IN_DFF) && rise && !arst && !apre) |=> (q_r == $past(d)));

  // R4: toggle on a detected rise when the conditioned sum is 1
  p_tff_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_TFF && rise && !arst && !apre) |=> (q_r == ($past(q_r) ^ $past(d))));

  // R3: edge modes hold without a rise
  p_edge_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (edge_m && !rise && !arst && !apre) |=> $stable(q_r));

  // R7: clear leaves a 0, even with set active
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
    arst |=> !q_r);

  // R8: set alone leaves a 1
  p_set_loads_r8: assert property (@(posedge clk) disable iff (rst)
    (apre && !arst) |=> q_r);
endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_pkg::*;
#(
  parameter int NUM_GCLK = 2,
  parameter bit BURIED   = 1'b0,
  localparam int GSEL_W = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic [GSEL_W-1:0]   cfg_clk_sel,
  input  logic [2:0]          cfg_mode,
  input  logic                cfg_inv,
  input  logic                cfg_pin_en,
  input  logic                sum_in,
  input  logic                nbr_pin,
  input  logic                arst,
  input  logic                apre,
  output logic                pin_q,
  output logic                fb_q
);
  mc_mode_e eff_mode;
  logic     d_sel;
  logic     g_lvl, g_rise;
  logic     res;

  // mode decode: input-register modes exist only in buried cells
  generate
    if (BURIED) begin : g_dec_buried
      always_comb begin
        case (cfg_mode)
          3'd1:    eff_mode = MD_DFF;
          3'd2:    eff_mode = MD_TFF;
          3'd3:    eff_mode = MD_LAT;
          3'd4:    eff_mode = MD_IN_DFF;
          3'd5:    eff_mode = MD_IN_LAT;
          default: eff_mode = MD_PASS;
        endcase
      end
    end else begin : g_dec_io
      always_comb begin
        case (cfg_mode)
          3'd1:    eff_mode = MD_DFF;
          3'd2:    eff_mode = MD_TFF;
          3'd3:    eff_mode = MD_LAT;
          default: eff_mode = MD_PASS;
        endcase
      end
    end
  endgenerate

  assign d_sel = (eff_mode == MD_IN_DFF || eff_mode == MD_IN_LAT) ? nbr_pin
                                                                   : (sum_in ^ cfg_inv);

  mc_clksel #(.NUM_GCLK(NUM_GCLK)) u_clk (
    .clk  (clk),
    .rst  (rst),
    .gclk (gclk),
    .sel  (cfg_clk_sel),
    .lvl  (g_lvl),
    .rise (g_rise)
  );

  mc_store u_st (
    .clk    (clk),
    .rst    (rst),
    .mode   (eff_mode),
    .d      (d_sel),
    .en_lvl (g_lvl),
    .rise   (g_rise),
    .arst   (arst),
    .apre   (apre),
    .res    (res)
  );

  assign fb_q = res;

  generate
    if (BURIED) begin : g_pin_none
      assign pin_q = 1'b0;
    end else begin : g_pin_drv
      assign pin_q = cfg_pin_en & res;
    end
  endgenerate

  // R9: an enabled pin mirrors the feedback path
  p_pin_mirror_r9: assert property (@(posedge clk) disable iff (rst)
    (!BURIED && cfg_pin_en) |-> (pin_q == fb_q));

  // R7: clear forces the feedback path low in the same cycle
  p_clear_now_r7: assert property (@(posedge clk) disable iff (rst)
    arst |-> !fb_q);
endmodule

// File: tb/sim_mc_cell.sv
module sim_mc_cell;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] gclk;
  logic [0:0] cfg_clk_sel;
  logic [2:0] cfg_mode;
  logic       cfg_inv, cfg_pin_en, sum_in, nbr_pin, arst, apre;
  logic       pin_q0, fb_q0, pin_q1, fb_q1;
  int         nvec = 0;
  int         nbad = 0;

  always #4 clk = ~clk;  // 125 MHz

  mc_cell #(.NUM_GCLK(2), .BURIED(1'b0)) u0 (
    .clk(clk), .rst(rst), .gclk(gclk), .cfg_clk_sel(cfg_clk_sel), .cfg_mode(cfg_mode),
    .cfg_inv(cfg_inv), .cfg_pin_en(cfg_pin_en), .sum_in(sum_in), .nbr_pin(nbr_pin),
    .arst(arst), .apre(apre), .pin_q(pin_q0), .fb_q(fb_q0));

  mc_cell #(.NUM_GCLK(2), .BURIED(1'b1)) u1 (
    .clk(clk), .rst(rst), .gclk(gclk), .cfg_clk_sel(cfg_clk_sel), .cfg_mode(cfg_mode),
    .cfg_inv(cfg_inv), .cfg_pin_en(cfg_pin_en), .sum_in(sum_in), .nbr_pin(nbr_pin),
    .arst(arst), .apre(apre), .pin_q(pin_q1), .fb_q(fb_q1));

  task automatic chk(string tag, logic act, logic exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // advance to the next falling edge (one rising edge passes)
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic pulse(int idx);
    gclk[idx] = 1'b1; tick();
    gclk[idx] = 1'b0; tick();
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(); tick();
    rst = 1'b0; tick();
  endtask

  task automatic t_reset();
    cfg_mode = 3'd1; do_reset(); settle();
    chk("R11 reset state fb", fb_q0, 1'b0);
    chk("R9 reset state pin", pin_q0, 1'b0);
  endtask

  task automatic t_pass();
    cfg_mode = 3'd0; cfg_inv = 1'b0; sum_in = 1'b1; settle();
    chk("R1 pass sum=1", fb_q0, 1'b1);
    cfg_inv = 1'b1; settle();
    chk("R1 pass inverted", fb_q0, 1'b0);
    cfg_mode = 3'd7; cfg_inv = 1'b0; sum_in = 1'b0; settle();
    chk("R1 code 7 as pass", fb_q0, 1'b0);
    sum_in = 1'b1; settle();
    chk("R1 code 7 follows", fb_q0, 1'b1);
    tick();
  endtask

  task automatic t_dff();
    do_reset();
    cfg_mode = 3'd1; cfg_inv = 1'b0; cfg_clk_sel = 1'b0; sum_in = 1'b1; tick();
    chk("R3 no rise holds", fb_q0, 1'b0);
    gclk[0] = 1'b1; settle();
    chk("R3 before edge", fb_q0, 1'b0);
    tick();
    chk("R3 captured", fb_q0, 1'b1);
    sum_in = 1'b0; tick(); tick();
    chk("R3 held while gclk high", fb_q0, 1'b1);
    gclk[0] = 1'b0; tick();
    pulse(0);
    chk("R3 second capture", fb_q0, 1'b0);
    cfg_inv = 1'b1; sum_in = 1'b0; pulse(0);
    chk("R2 inverted capture", fb_q0, 1'b1);
    cfg_inv = 1'b0;
  endtask

  task automatic t_tff();
    do_reset();
    cfg_mode = 3'd2; cfg_inv = 1'b0; cfg_clk_sel = 1'b0; sum_in = 1'b1;
    pulse(0);
    chk("R4 toggle to 1", fb_q0, 1'b1);
    sum_in = 1'b0; pulse(0);
    chk("R4 hold on 0", fb_q0, 1'b1);
    cfg_inv = 1'b1; pulse(0);
    chk("R4 toggle on inverted 0", fb_q0, 1'b0);
    cfg_inv = 1'b0;
  endtask

  task automatic t_latch();
    do_reset();
    cfg_mode = 3'd3; cfg_inv = 1'b0; cfg_clk_sel = 1'b0; sum_in = 1'b1; settle();
    chk("R5 closed holds", fb_q0, 1'b0);
    gclk[0] = 1'b1; settle();
    chk("R5 transparent 1", fb_q0, 1'b1);
    sum_in = 1'b0; settle();
    chk("R5 transparent 0", fb_q0, 1'b0);
    tick();
    sum_in = 1'b1; tick();
    gclk[0] = 1'b0; sum_in = 1'b0; settle();
    chk("R5 close keeps last", fb_q0, 1'b1);
    tick(); tick();
    chk("R5 stays closed", fb_q0, 1'b1);
  endtask

  task automatic t_clksel();
    do_reset();
    cfg_mode = 3'd1; cfg_clk_sel = 1'b1; sum_in = 1'b1;
    pulse(0);
    chk("R6 other clock ignored", fb_q0, 1'b0);
    pulse(1);
    chk("R6 selected clock", fb_q0, 1'b1);
    cfg_clk_sel = 1'b0;
  endtask

  task automatic t_force();
    do_reset();
    cfg_mode = 3'd1; sum_in = 1'b1; pulse(0);
    chk("R3 setup 1", fb_q0, 1'b1);
    arst = 1'b1; apre = 1'b1; settle();
    chk("R7 clear wins now", fb_q0, 1'b0);
    tick();
    arst = 1'b0; settle();
    chk("R8 set now", fb_q0, 1'b1);
    tick();
    apre = 1'b0; settle();
    chk("R8 set stored", fb_q0, 1'b1);
    arst = 1'b1; tick();
    arst = 1'b0; settle();
    chk("R7 clear stored", fb_q0, 1'b0);
    arst = 1'b1; apre = 1'b1; gclk[0] = 1'b1; tick();
    arst = 1'b0; apre = 1'b0; gclk[0] = 1'b0; settle();
    chk("R7 clear beats set and rise", fb_q0, 1'b0);
    tick();
  endtask

  task automatic t_pin();
    do_reset();
    cfg_mode = 3'd0; cfg_inv = 1'b0; sum_in = 1'b1; cfg_pin_en = 1'b1; settle();
    chk("R9 pin on", pin_q0, 1'b1);
    cfg_pin_en = 1'b0; settle();
    chk("R9 pin off", pin_q0, 1'b0);
    chk("R9 fb unaffected", fb_q0, 1'b1);
    chk("R9 buried pin", pin_q1, 1'b0);
    chk("R9 buried fb", fb_q1, 1'b1);
    cfg_pin_en = 1'b1; tick();
  endtask

  task automatic t_buried();
    do_reset();
    cfg_mode = 3'd4; cfg_inv = 1'b1; sum_in = 1'b1; nbr_pin = 1'b1; settle();
    chk("R10 io cell code 4 as pass", fb_q0, 1'b0);
    chk("R10 input reg before edge", fb_q1, 1'b0);
    pulse(0);
    chk("R10 input reg capture", fb_q1, 1'b1);
    nbr_pin = 1'b0; tick();
    chk("R10 input reg holds", fb_q1, 1'b1);
    cfg_mode = 3'd5; settle();
    chk("R10 input latch closed", fb_q1, 1'b1);
    gclk[0] = 1'b1; settle();
    chk("R10 input latch open", fb_q1, 1'b0);
    gclk[0] = 1'b0; cfg_inv = 1'b0; tick();
  endtask

  task automatic t_sync_rst();
    cfg_mode = 3'd1; sum_in = 1'b1; pulse(0);
    chk("R11 preload", fb_q0, 1'b1);
    rst = 1'b1; tick();
    rst = 1'b0; settle();
    chk("R11 cleared", fb_q0, 1'b0);
    tick();
  endtask

  initial begin
    rst = 1'b1; gclk = '0; cfg_clk_sel = '0; cfg_mode = 3'd0; cfg_inv = 1'b0;
    cfg_pin_en = 1'b1; sum_in = 1'b0; nbr_pin = 1'b0; arst = 1'b0; apre = 1'b0;
    fork
      begin
        t_reset();
        t_pass();
        t_dff();
        t_tff();
        t_latch();
        t_clksel();
        t_force();
        t_pin();
        t_buried();
        t_sync_rst();
      end
      begin
        repeat (20000) @(posedge clk);
        nvec++; nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule